// File: doc/BRIEF.md
# Operand Address Decoder for Register/Memory Addressing Bytes

This block takes the addressing bytes of a two-operand instruction, one byte per accepted handshake, and resolves the second operand. A `start` pulse opens a sequence. The first byte is the ModR/M byte. From its fields the block decides whether a scale-index-base (SIB) byte follows and how many displacement bytes come after that: none, one or four. Once the last byte has arrived, it reads the base and index registers through two read ports into an external eight-entry register file. It then reports whether the operand is a register or a memory location, and for a memory operand it gives the 32-bit effective address.

The block is meant to sit behind an instruction byte stream in a decode stage. The upstream logic has already handled prefixes and the opcode, and it supplies only the addressing bytes. Immediates, segment arithmetic and the memory access itself belong to other blocks.

Top module: `ea_operand_decoder`

## Requirements
- R1: `in_ready` is low after reset and while idle. It goes high in the cycle after an accepted `start` and stays high until the final addressing byte is accepted. A byte is consumed only on a clock edge where `in_valid` and `in_ready` are both high.
- R2: Bits 5:3 of the ModR/M byte appear on `reg_field` and bits 2:0 appear on `rm_field` with each result.
- R3: When bits 7:6 of the ModR/M byte are 11, the operand is a register: `is_mem`=0, `byte_count`=1, `eff_addr`=0, and `rm_field` gives the register number.
- R4: When MOD is 00, 01 or 10 and R/M is 100, a SIB byte follows the ModR/M byte, and any displacement comes after the SIB byte. `byte_count` is then 2, 3 or 6 for MOD 00, 01 or 10.
- R5: When MOD is 00 and R/M is 101, four displacement bytes follow and no register is used. `eff_addr` equals the displacement and `byte_count` is 5.
- R6: For every other memory form, the base register number equals R/M. MOD 00, 01 and 10 add 0, 1 and 4 displacement bytes, giving `byte_count` 1, 2 or 5.
- R7: The SIB byte carries scale in bits 7:6, index in bits 5:3 and base in bits 2:0. The address is base + (index << scale), so scale codes 00/01/10/11 multiply by 1/2/4/8, plus the displacement. An index code of 100 removes the index term. Every base code, 101 included, names a register.
- R8: A one-byte displacement is sign-extended. A four-byte displacement arrives least-significant byte first. All address sums wrap modulo 2^32.
- R9: `done` is high for exactly one cycle. It rises on the first clock edge after the edge that accepted the final byte. The result outputs change only on that edge and hold until the next result.
- R10: `start` has no effect while a sequence is in progress. Bytes offered while `in_ready` is low are not consumed and do not alter the result.
- R11: During and right after reset, `done` and `in_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opens a new addressing sequence when idle |
| in_valid | input | 1 | An addressing byte is offered |
| in_byte | input | 8 | Offered addressing byte |
| in_ready | output | 1 | Block can consume a byte this cycle |
| rf_base_sel | output | 3 | Register file read address for the base |
| rf_base_val | input | AW | Register file read data for the base |
| rf_index_sel | output | 3 | Register file read address for the index |
| rf_index_val | input | AW | Register file read data for the index |
| done | output | 1 | One-cycle result strobe |
| is_mem | output | 1 | 1 = memory operand, 0 = register operand |
| reg_field | output | 3 | REG field of the ModR/M byte |
| rm_field | output | 3 | R/M field; the register number for register operands |
| eff_addr | output | AW | Effective address of a memory operand |
| byte_count | output | 3 | Addressing bytes consumed, 1 to 6 |

## Verification
Every byte is taken on the clock edge where it is offered with `in_ready` high. The result follows exactly one edge after the final byte is accepted. The bench therefore drives bytes on falling edges and samples on falling edges. In the first sample after the final byte it expects `done` low. In the next sample it expects `done` high with every result field. In the sample after that it expects `done` low again. Random idle gaps and stray `start` pulses inside a sequence move only the point where the next byte is taken, never this one-edge result latency. The bench follows each byte acceptance instead of counting cycles from `start`.

// File: rtl/ea_dec_pkg.sv
package ea_dec_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_MODRM,
      ST_SIB,
      ST_DISP,
      ST_CALC
   } ea_state_e;

   localparam logic [1:0] MD_NODISP = 2'b00;
   localparam logic [1:0] MD_DISP8  = 2'b01;
   localparam logic [1:0] MD_DISP32 = 2'b10;
   localparam logic [1:0] MD_REG    = 2'b11;

   localparam logic [2:0] RM_SIB    = 3'b100;
   localparam logic [2:0] RM_DIRECT = 3'b101;
   localparam logic [2:0] IX_NONE   = 3'b100;

   localparam int FIELD_W   = 3;
   localparam int LONG_DISP = 4;

endpackage

// File: rtl/ea_modrm_classify.sv
module ea_modrm_classify
   import ea_dec_pkg::*;
(
   input  logic [1:0] md,
   input  logic [2:0] rm,
   output logic       is_reg,
   output logic       needs_sib,
   output logic       is_direct,
   output logic [2:0] disp_bytes
);

   always_comb begin
      is_reg     = (md == MD_REG);
      needs_sib  = !is_reg && (rm == RM_SIB);
      is_direct  = (md == MD_NODISP) && (rm == RM_DIRECT);
      disp_bytes = 3'd0;
      unique case (md)
         MD_DISP8:  disp_bytes = 3'd1;
         MD_DISP32: disp_bytes = 3'(LONG_DISP);
         MD_NODISP: disp_bytes = is_direct ? 3'(LONG_DISP) : 3'd0;
         default:   disp_bytes = 3'd0;
      endcase
   end

endmodule

// File: rtl/ea_disp_gather.sv
module ea_disp_gather #(
   parameter int AW = 32,
   parameter int NB = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  wr,
   input  logic [$clog2(NB)-1:0] lane,
   input  logic [7:0]            din,
   input  logic                  short_form,
   output logic [AW-1:0]         dout
);

   localparam int LW = $clog2(NB);

   logic [8*NB-1:0] packed_q;

   for (genvar g = 0; g < NB; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            packed_q[8*g +: 8] <= 8'h00;
         end else if (clr) begin
            packed_q[8*g +: 8] <= 8'h00;
         end else if (wr && (lane == LW'(g))) begin
            packed_q[8*g +: 8] <= din;
         end
      end
   end

   logic signed [7:0]      low_s;
   logic signed [8*NB-1:0] full_s;

   always_comb begin
      low_s  = $signed(packed_q[7:0]);
      full_s = $signed(packed_q);
      dout   = short_form ? AW'(low_s) : AW'(full_s);
   end

endmodule

// File: rtl/ea_addr_gen.sv
module ea_addr_gen #(
   parameter int AW     = 32,
   parameter bit CSA_EN = 1'b1
) (
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] index,
   input  logic [1:0]    scale,
   input  logic [AW-1:0] disp,
   output logic [AW-1:0] sum
);

   logic [AW-1:0] scaled;

   assign scaled = index << scale;

   if (CSA_EN) begin : g_csa
      logic [AW-1:0] part_s;
      logic [AW-1:0] part_c;
      always_comb begin
         part_s = base ^ scaled ^ disp;
         part_c = ((base & scaled) | (base & disp) | (scaled & disp)) << 1;
         sum    = part_s + part_c;
      end
   end else begin : g_chain
      assign sum = base + scaled + disp;
   end

endmodule

// File: rtl/ea_operand_decoder.sv
module ea_operand_decoder
   import ea_dec_pkg::*;
#(
   parameter int AW     = 32,
   parameter bit CSA_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          in_valid,
   input  logic [7:0]    in_byte,
   output logic          in_ready,
   output logic [2:0]    rf_base_sel,
   input  logic [AW-1:0] rf_base_val,
   output logic [2:0]    rf_index_sel,
   input  logic [AW-1:0] rf_index_val,
   output logic          done,
   output logic          is_mem,
   output logic [2:0]    reg_field,
   output logic [2:0]    rm_field,
   output logic [AW-1:0] eff_addr,
   output logic [2:0]    byte_count
);

   localparam int NB = LONG_DISP;
   localparam int LW = $clog2(NB);

   if (AW < 8 * NB || (AW % 8) != 0) begin : g_bad_aw
      $error("AW must be a byte multiple of at least 32");
   end
   if (FIELD_W != 3) begin : g_bad_field
      $error("addressing fields must be three bits wide");
   end

   ea_state_e      st;
   logic [1:0]     md_q, scl_q;
   logic [2:0]     reg_q, rm_q, idx_q, bas_q;
   logic [2:0]     left_q, cnt_q;
   logic [LW-1:0]  lane_q;

   logic           done_q, is_mem_q;
   logic [2:0]     reg_out_q, rm_out_q, count_q;
   logic [AW-1:0]  ea_q;

   logic           take;
   logic [1:0]     c_md;
   logic [2:0]     c_rm, c_dlen;
   logic           c_is_reg, c_sib, c_direct;
   logic           has_sib, use_base, use_index;
   logic [AW-1:0]  disp_val, agen_sum, base_term, index_term;

   assign in_ready = (st == ST_MODRM) || (st == ST_SIB) || (st == ST_DISP);
   assign take     = in_valid && in_ready;

   assign c_md = (st == ST_MODRM) ? in_byte[7:6] : md_q;
   assign c_rm = (st == ST_MODRM) ? in_byte[2:0] : rm_q;

   ea_modrm_classify u_cls (
      .md         (c_md),
      .rm         (c_rm),
      .is_reg     (c_is_reg),
      .needs_sib  (c_sib),
      .is_direct  (c_direct),
      .disp_bytes (c_dlen)
   );

   ea_disp_gather #(.AW(AW), .NB(NB)) u_disp (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        ((st == ST_IDLE) && start),
      .wr         (take && (st == ST_DISP)),
      .lane       (lane_q),
      .din        (in_byte),
      .short_form (md_q == MD_DISP8),
      .dout       (disp_val)
   );

   assign has_sib      = (md_q != MD_REG) && (rm_q == RM_SIB);
   assign rf_base_sel  = has_sib ? bas_q : rm_q;
   assign rf_index_sel = idx_q;
   assign use_base     = has_sib || !c_direct;
   assign use_index    = has_sib && (idx_q != IX_NONE);
   assign base_term    = use_base  ? rf_base_val  : '0;
   assign index_term   = use_index ? rf_index_val : '0;

   ea_addr_gen #(.AW(AW), .CSA_EN(CSA_EN)) u_agen (
      .base  (base_term),
      .index (index_term),
      .scale (has_sib ? scl_q : 2'b00),
      .disp  (disp_val),
      .sum   (agen_sum)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         md_q      <= 2'b00;
         scl_q     <= 2'b00;
         reg_q     <= 3'd0;
         rm_q      <= 3'd0;
         idx_q     <= 3'd0;
         bas_q     <= 3'd0;
         left_q    <= 3'd0;
         cnt_q     <= 3'd0;
         lane_q    <= '0;
         done_q    <= 1'b0;
         is_mem_q  <= 1'b0;
         reg_out_q <= 3'd0;
         rm_out_q  <= 3'd0;
         count_q   <= 3'd0;
         ea_q      <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (start) begin
                  st     <= ST_MODRM;
                  cnt_q  <= 3'd0;
                  lane_q <= '0;
               end
            end
            ST_MODRM: begin
               if (take) begin
                  md_q  <= in_byte[7:6];
                  reg_q <= in_byte[5:3];
                  rm_q  <= in_byte[2:0];
                  cnt_q <= 3'd1;
                  if (c_is_reg) begin
                     st <= ST_CALC;
                  end else if (c_sib) begin
                     st <= ST_SIB;
                  end else if (c_dlen != 3'd0) begin
                     st     <= ST_DISP;
                     left_q <= c_dlen;
                  end else begin
                     st <= ST_CALC;
                  end
               end
            end
            ST_SIB: begin
               if (take) begin
                  scl_q <= in_byte[7:6];
                  idx_q <= in_byte[5:3];
                  bas_q <= in_byte[2:0];
                  cnt_q <= cnt_q + 3'd1;
                  if (c_dlen != 3'd0) begin
                     st     <= ST_DISP;
                     left_q <= c_dlen;
                  end else begin
                     st <= ST_CALC;
                  end
               end
            end
            ST_DISP: begin
               if (take) begin
                  cnt_q  <= cnt_q + 3'd1;
                  lane_q <= lane_q + 1'b1;
                  left_q <= left_q - 3'd1;
                  if (left_q == 3'd1) st <= ST_CALC;
               end
            end
            ST_CALC: begin
               done_q    <= 1'b1;
               is_mem_q  <= (md_q != MD_REG);
               ea_q      <= (md_q == MD_REG) ? '0 : agen_sum;
               count_q   <= cnt_q;
               reg_out_q <= reg_q;
               rm_out_q  <= rm_q;
               st        <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign done       = done_q;
   assign is_mem     = is_mem_q;
   assign reg_field  = reg_out_q;
   assign rm_field   = rm_out_q;
   assign eff_addr   = ea_q;
   assign byte_count = count_q;

endmodule

// File: rtl/ea_operand_decoder_chk.sv
module ea_operand_decoder_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_ready,
   input logic          done,
   input logic          is_mem,
   input logic [2:0]    rm_field,
   input logic [AW-1:0] eff_addr,
   input logic [2:0]    byte_count
);

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9

   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(eff_addr) |-> done); // R9

   AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !in_ready); // R1

   AST_REG_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !is_mem) |-> (byte_count == 3'd1 && eff_addr == '0)); // R3

   AST_SIB_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      (done && is_mem && rm_field == 3'b100) |->
         (byte_count == 3'd2 || byte_count == 3'd3 || byte_count == 3'd6)); // R4

   AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (byte_count >= 3'd1 && byte_count <= 3'd6)); // R6

endmodule

bind ea_operand_decoder ea_operand_decoder_chk #(.AW(AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_ready   (in_ready),
   .done       (done),
   .is_mem     (is_mem),
   .rm_field   (rm_field),
   .eff_addr   (eff_addr),
   .byte_count (byte_count)
);

// File: tb/ea_operand_decoder_test.sv
module ea_operand_decoder_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_byte = 8'h00;
   logic        in_ready;
   logic [2:0]  rf_base_sel, rf_index_sel;
   logic [31:0] rf_base_val, rf_index_val;
   logic        done, is_mem;
   logic [2:0]  reg_field, rm_field, byte_count;
   logic [31:0] eff_addr;

   logic [31:0] rf [8];
   int checks = 0;
   int fails = 0;
   logic [31:0] last_ea;
   logic [2:0]  last_cnt;

   always #4 clk = ~clk;

   assign rf_base_val  = rf[rf_base_sel];
   assign rf_index_val = rf[rf_index_sel];

   ea_operand_decoder uut (
      .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
      .in_byte(in_byte), .in_ready(in_ready),
      .rf_base_sel(rf_base_sel), .rf_base_val(rf_base_val),
      .rf_index_sel(rf_index_sel), .rf_index_val(rf_index_val),
      .done(done), .is_mem(is_mem), .reg_field(reg_field),
      .rm_field(rm_field), .eff_addr(eff_addr), .byte_count(byte_count)
   );

   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   function automatic int disp_len(input logic [1:0] md, input logic [2:0] rm);
      if (md == 2'b01) return 1;
      if (md == 2'b10) return 4;
      if (md == 2'b00 && rm == 3'b101) return 4;
      return 0;
   endfunction

   function automatic int exp_count(input logic [7:0] m);
      if (m[7:6] == 2'b11) return 1;
      return 1 + ((m[2:0] == 3'b100) ? 1 : 0) + disp_len(m[7:6], m[2:0]);
   endfunction

   function automatic logic [31:0] exp_ea(input logic [7:0] m, input logic [7:0] s,
                                          input logic [31:0] d);
      logic [31:0] dv, ix;
      if (m[7:6] == 2'b11) return 32'h0;
      if (m[7:6] == 2'b01) dv = {{24{d[7]}}, d[7:0]};
      else if (disp_len(m[7:6], m[2:0]) == 4) dv = d;
      else dv = 32'h0;
      if (m[2:0] == 3'b100) begin
         ix = (s[5:3] == 3'b100) ? 32'h0 : (rf[s[5:3]] << s[7:6]);
         return rf[s[2:0]] + ix + dv;
      end
      if (m[7:6] == 2'b00 && m[2:0] == 3'b101) return d;
      return rf[m[2:0]] + dv;
   endfunction

   task automatic run_case(input logic [7:0] m, input logic [7:0] s,
                           input logic [31:0] d, input bit gaps);
      logic [7:0] bq [6];
      int n = 0;
      int dl;
      bq[n++] = m;
      if (m[7:6] != 2'b11) begin
         if (m[2:0] == 3'b100) bq[n++] = s;
         dl = disp_len(m[7:6], m[2:0]);
         for (int k = 0; k < dl; k++) bq[n++] = d[8*k +: 8];
      end
      // R10: a byte offered while idle must not be consumed
      in_valid = 1'b1;
      in_byte  = 8'hC5;
      @(negedge clk);
      start = 1'b1;
      in_valid = 1'b0;
      @(negedge clk);
      start = 1'b0;
      check(in_ready == 1'b1, "R1 ready after start", in_ready, 1);
      for (int i = 0; i < n; i++) begin
         if (gaps) begin
            int g = $urandom_range(0, 2);
            repeat (g) begin
               in_valid = 1'b0;
               start = 1'($urandom_range(0, 1)); // R10 stray start
               @(negedge clk);
            end
         end
         start = 1'b0;
         in_valid = 1'b1;
         in_byte = bq[i];
         @(negedge clk);
      end
      in_valid = 1'b0;
      check(done == 1'b0 && in_ready == 1'b0, "R9 result not early / R1 ready dropped",
            {done, in_ready}, 0);
      @(negedge clk);
      check(done == 1'b1, "R9 done pulse", done, 1);
      check(is_mem == (m[7:6] != 2'b11), "R3 operand kind", is_mem, m[7:6] != 2'b11);
      check(reg_field == m[5:3] && rm_field == m[2:0], "R2 fields",
            {reg_field, rm_field}, {m[5:3], m[2:0]});
      check(byte_count == 3'(exp_count(m)), "R4 R5 R6 byte count", byte_count,
            exp_count(m));
      check(eff_addr == exp_ea(m, s, d), "R7 R8 effective address", eff_addr,
            exp_ea(m, s, d));
      last_ea  = eff_addr;
      last_cnt = byte_count;
      @(negedge clk);
      check(done == 1'b0 && eff_addr == last_ea, "R9 single pulse and hold",
            {done, eff_addr}, {1'b0, last_ea});
   endtask

   task automatic fill_rf();
      for (int k = 0; k < 8; k++) rf[k] = $urandom;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      report();
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED1234));
      fill_rf();
      repeat (3) @(negedge clk);
      check(done == 1'b0 && in_ready == 1'b0, "R11 in reset", {done, in_ready}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(done == 1'b0 && in_ready == 1'b0, "R11 after reset", {done, in_ready}, 0);

      // R5 direct address
      run_case(8'h05, 8'h00, 32'h12345678, 1'b0);
      check(last_ea == 32'h12345678 && last_cnt == 3'd5, "R5 direct literal",
            last_ea, 32'h12345678);

      // R7 array element: base 5 + 4*reg0 + 8
      rf[5] = 32'h0000_1000; rf[0] = 32'd3;
      run_case(8'h44, 8'h85, 32'h0000_0008, 1'b0);
      check(last_ea == 32'h0000_1014 && last_cnt == 3'd3, "R7 array literal",
            last_ea, 32'h1014);

      // R8 negative short displacement
      rf[3] = 32'h0000_0100;
      run_case(8'h43, 8'h00, 32'h0000_00F0, 1'b0);
      check(last_ea == 32'h0000_00F0, "R8 sign extension literal", last_ea, 32'hF0);

      // R8 wrap modulo 2^32
      rf[1] = 32'hFFFF_FFF0;
      run_case(8'h81, 8'h00, 32'h0000_0020, 1'b0);
      check(last_ea == 32'h0000_0010, "R8 wrap literal", last_ea, 32'h10);

      // R7 scale 8 with no-index code and scale 8 with index
      rf[2] = 32'h10; rf[6] = 32'h100;
      run_case(8'h04, 8'hE2, 32'h0, 1'b0);
      check(last_ea == 32'h10, "R7 no index literal", last_ea, 32'h10);
      run_case(8'h04, 8'hF2, 32'h0, 1'b0);
      check(last_ea == 32'h810, "R7 scale 8 literal", last_ea, 32'h810);

      // R3 R6 every MOD/R/M combination, random REG, SIB, displacement
      for (int rep = 0; rep < 3; rep++) begin
         for (int md = 0; md < 4; md++) begin
            for (int r = 0; r < 8; r++) begin
               logic [7:0] mb;
               fill_rf();
               mb = {2'(md), 3'($urandom_range(0, 7)), 3'(r)};
               run_case(mb, 8'($urandom), $urandom, rep != 0);
            end
         end
      end

      // R7 sweep of all SIB values
      for (int sv = 0; sv < 256; sv++) begin
         logic [7:0] mb;
         fill_rf();
         mb = {2'($urandom_range(0, 2)), 3'($urandom_range(0, 7)), 3'b100};
         run_case(mb, 8'(sv), $urandom, sv[0]);
      end

      report();
      $finish;
   end

endmodule